// File: doc/BRIEF.md
# ADC channel-queue conversion sequencer

This block sequences conversions for a multi-channel converter. Software drives it through a small 8-bit register port. It hands channel numbers to an external conversion engine with a one-cycle start pulse and a channel bus. When the engine reports done, the block latches the result, raises a completion flag and can raise an interrupt.

In single mode, every write to the control register cancels the conversion in progress. A new conversion then starts on the written channel, as long as that channel is valid. In queue mode, each control-register write appends a channel to a FIFO of up to eight entries. Conversion begins once the FIFO holds the programmed depth, and the channels are converted in write order. With continuous mode set, single mode repeats the same channel and queue mode rewinds to the first entry.

Top module: `adc_queue_seq`

## Requirements
- R1: After reset, register 0 (control: bit 7 done flag, bit 6 interrupt enable, bit 5 continuous, bits 4:0 channel) reads 0x1F. At that point `conv_start` and `irq` are low.
- R2: In single mode, a control write with channel 0..23 raises `conv_start` for one cycle, starting on the edge after the write, with `conv_chan` set to that channel. Any conversion in progress is dropped.
- R3: In single mode, a control write with channel 24..31 starts nothing and stops any active conversion. A later `conv_done` then leaves the flag clear.
- R4: A `conv_done` during an active conversion latches `conv_result`. Register 2 then reads {4'b0, result[11:8]}, register 3 reads result[7:0], and control bit 7 reads 1.
- R5: A read strobe on register 3 or any control write clears the done flag. If a read of register 3 falls in the same cycle as `conv_done`, the flag ends up set.
- R6: `irq` is high exactly when the done flag and the interrupt-enable bit are both set.
- R7: In single mode with continuous set, `conv_start` pulses again for the same channel on the edge that accepts `conv_done`.
- R8: Register 1 selects the mode: bit 3 enables the queue, and bits 2:0 hold the depth minus one. In queue mode, no conversion starts until the number of queued entries equals the depth.
- R9: Queued channels convert in write order, one start per accepted done. When continuous is clear, the last completion stops the block and empties the queue.
- R10: In queue mode with continuous set, the completion of the last entry restarts the first entry.
- R11: In queue mode, writes of channels 24..30 are ignored, and so are writes made once the queue holds the depth.
- R12: In queue mode, a control write of channel 31 empties the queue and halts any active conversion.
- R13: A write to register 1 empties the queue and stops any active conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| conv_start | output | 1 | One-cycle request to the engine |
| conv_chan | output | 5 | Channel for the requested conversion |
| conv_done | input | 1 | Engine completion pulse |
| conv_result | input | 12 | Engine result, valid with `conv_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the engine raises `conv_done` only while a conversion is outstanding, and only for one cycle at a time. They also assume that writes and done pulses never arrive in the same cycle unless an abort is being tested. The stimulus follows these rules: each done pulse is driven after a start has been observed, strobes last exactly one cycle, and every input changes on the falling edge. The flush and reserved-code properties hold for any write data, so those writes are not restricted.

// File: rtl/adc_queue_seq.sv
module adc_queue_seq #(
  parameter int CH_W   = 5,
  parameter int NUM_CH = 24,
  parameter int RES_W  = 12,
  parameter int QMAX   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             irq
);
  localparam int QW  = $clog2(QMAX);
  localparam int CW  = QW + 1;
  localparam logic [CH_W-1:0] IDLE = '1;

  logic            ie, cont, qen, flag, busy;
  logic [CH_W-1:0] ch_reg;
  logic [QW-1:0]   depth, idx;
  logic [CW-1:0]   cnt;
  logic [RES_W-1:0] result;
  logic [CH_W-1:0] fifo [QMAX];

  wire [CH_W-1:0] wch     = reg_wdata[CH_W-1:0];
  wire            ch_ok   = 32'(wch) < NUM_CH;
  wire            wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire            wr_cfg  = reg_wr && reg_addr == 2'd1;
  wire            rd_lo   = reg_rd && reg_addr == 2'd3;
  wire [CW-1:0]   depth_n = {1'b0, depth} + CW'(1);
  wire            push    = wr_ctrl && qen && ch_ok && cnt < depth_n;

  assign irq = flag & ie;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {flag, ie, cont, ch_reg};
      2'd1:    reg_rdata = {4'b0, qen, depth};
      2'd2:    reg_rdata = 8'(result >> 8);
      default: reg_rdata = result[7:0];
    endcase
  end

  always_ff @(posedge clk)
    if (push) fifo[cnt[QW-1:0]] <= wch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; cont <= 1'b0; ch_reg <= IDLE;
      qen <= 1'b0; depth <= '0; flag <= 1'b0; busy <= 1'b0;
      result <= '0; conv_start <= 1'b0; conv_chan <= '0;
      cnt <= '0; idx <= '0;
    end else begin
      conv_start <= 1'b0;
      if (rd_lo) flag <= 1'b0;
      if (wr_ctrl) begin
        flag <= 1'b0;
        ie <= reg_wdata[6]; cont <= reg_wdata[5]; ch_reg <= wch;
        if (!qen) begin
          busy <= ch_ok;
          if (ch_ok) begin
            conv_start <= 1'b1;
            conv_chan  <= wch;
          end
        end else if (wch == IDLE) begin
          busy <= 1'b0; cnt <= '0; idx <= '0;
        end else if (push) begin
          cnt <= cnt + CW'(1);
          if (cnt + CW'(1) == depth_n && !busy) begin
            busy <= 1'b1; idx <= '0; conv_start <= 1'b1;
            conv_chan <= (cnt == '0) ? wch : fifo[0];
          end
        end
      end else if (wr_cfg) begin
        qen <= reg_wdata[3]; depth <= reg_wdata[QW-1:0];
        busy <= 1'b0; cnt <= '0; idx <= '0;
      end else if (busy && conv_done) begin
        flag <= 1'b1;
        result <= conv_result;
        if (!qen) begin
          if (cont) conv_start <= 1'b1;
          else      busy <= 1'b0;
        end else if (idx == depth) begin
          if (cont) begin
            idx <= '0; conv_start <= 1'b1; conv_chan <= fifo[0];
          end else begin
            busy <= 1'b0; cnt <= '0; idx <= '0;
          end
        end else begin
          idx <= idx + QW'(1);
          conv_start <= 1'b1;
          conv_chan <= fifo[idx + QW'(1)];
        end
      end
    end
  end

  AST_START_VALID_CH: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> 32'(conv_chan) < NUM_CH);  // R3
  AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(conv_done && busy));  // R4
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= depth_n);  // R11
  AST_QUEUE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && qen && wch == IDLE) |=> (!busy && cnt == '0));  // R12
  AST_CFG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> !busy && !conv_start);  // R13
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !conv_done && !reg_wr) |=> !conv_start);  // R2
endmodule

// File: tb/adc_queue_seq_bench.sv
module adc_queue_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, conv_done = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic conv_start, irq;
  logic [4:0] conv_chan;
  logic [11:0] conv_result = 0;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_queue_seq u_adc_queue_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq));

  // {channel, result}
  localparam logic [16:0] VEC [0:3] = '{
    {5'd0, 12'h123}, {5'd23, 12'hFFF}, {5'd12, 12'h000}, {5'd7, 12'hA5C}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit strobe, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = strobe; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic done(input logic [11:0] r);
    @(negedge clk); conv_done = 1; conv_result = r;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic start_is(input string req, input logic [4:0] ch);
    chk(conv_start === 1'b1 && conv_chan === ch, req, {conv_start, conv_chan}, {1'b1, ch});
  endtask

  task automatic no_start(input string req);
    chk(conv_start === 1'b0, req, conv_start, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1;
    rd(0, 0, rv);
    chk(rv == 8'h1F, "R1 ctrl reset", rv, 8'h1F);
    chk(conv_start == 0 && irq == 0, "R1 outputs", {conv_start, irq}, 0);

    for (int i = 0; i < 4; i++) begin
      wr(0, {3'b000, VEC[i][16:12]});
      start_is("R2 single start", VEC[i][16:12]);
      @(negedge clk); no_start("R2 one-cycle pulse");
      done(VEC[i][11:0]);
      rd(0, 0, rv); chk(rv[7] == 1, "R4 flag set", rv[7], 1);
      rd(2, 1, rv); chk(rv == {4'b0, VEC[i][11:8]}, "R4 result high", rv, {4'b0, VEC[i][11:8]});
      rd(3, 1, rv); chk(rv == VEC[i][7:0], "R4 result low", rv, VEC[i][7:0]);
      rd(0, 0, rv); chk(rv[7] == 0, "R5 read low clears", rv[7], 0);
    end

    wr(0, 8'h07); start_is("R2 start", 7);
    wr(0, 8'h1F); no_start("R3 idle code");
    done(12'h111); rd(0, 0, rv); chk(rv[7] == 0, "R3 abort ignores done", rv[7], 0);
    wr(0, 8'h19); no_start("R3 reserved 25");

    wr(0, 8'h43); start_is("R6 start", 3);
    chk(irq == 0, "R6 irq low before done", irq, 0);
    done(12'h222); chk(irq == 1, "R6 irq set", irq, 1);
    rd(3, 1, rv); chk(irq == 0, "R6 irq cleared", irq, 0);

    wr(0, 8'h02);
    @(negedge clk); conv_done = 1; conv_result = 12'h333; reg_addr = 3; reg_rd = 1;
    @(negedge clk); conv_done = 0; reg_rd = 0;
    rd(0, 0, rv); chk(rv[7] == 1, "R5 set wins over read", rv[7], 1);
    wr(0, 8'h1F); rd(0, 0, rv); chk(rv[7] == 0, "R5 ctrl write clears", rv[7], 0);

    wr(0, 8'h29); start_is("R7 first", 9);
    done(12'h444); start_is("R7 restart", 9);
    done(12'h445); start_is("R7 restart again", 9);
    wr(0, 8'h1F);

    wr(1, 8'h0A);
    wr(0, 8'h04); no_start("R8 1 of 3");
    wr(0, 8'h1A); no_start("R11 reserved in queue");
    wr(0, 8'h0B); no_start("R8 2 of 3");
    wr(0, 8'h06); start_is("R8 full starts first", 4);
    wr(0, 8'h0D); no_start("R11 past depth");
    done(12'h001); start_is("R9 second", 11);
    done(12'h002); start_is("R9 third", 6);
    done(12'h003); no_start("R9 stops at end");
    wr(0, 8'h0D); no_start("R9 queue emptied");
    wr(0, 8'h1F);
    wr(0, 8'h01); no_start("R12 after flush 1");
    wr(0, 8'h02); no_start("R12 after flush 2");
    wr(0, 8'h03); start_is("R12 refill start", 1);
    wr(0, 8'h1F); done(12'h004);
    rd(0, 0, rv); chk(rv[7] == 0, "R12 halt ignores done", rv[7], 0);

    wr(0, 8'h01); wr(0, 8'h02); wr(0, 8'h03); start_is("R13 pre", 1);
    wr(1, 8'h08); no_start("R13 cfg write");
    done(12'h005); rd(0, 0, rv); chk(rv[7] == 0, "R13 stopped", rv[7], 0);

    wr(0, 8'h25); start_is("R10 depth1", 5);
    done(12'h006); start_is("R10 depth1 rewind", 5);
    wr(1, 8'h09);
    wr(0, 8'h27); no_start("R10 partial");
    wr(0, 8'h28); start_is("R10 first", 7);
    done(12'h007); start_is("R10 second", 8);
    done(12'h008); start_is("R10 rewind", 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule